// File: doc/BRIEF.md
# Nine-bit capable asynchronous serial port

This block is a full-duplex asynchronous serial port. One control register sets it up. It can send and receive either 8-bit or 9-bit data words, each with an optional parity bit. The CPU-side interface is a plain register bus with a write strobe, a read strobe, a two-bit address and a 16-bit data path. The block has one serial output, one serial input and a single level interrupt line. The bit rate comes from a fixed divider parameter. One bit lasts 16 ticks of that divider, so a bit lasts `16*DIV` clocks.

On the transmit side, a one-word holding register feeds a frame shifter. In 9-bit framing, the extra data bit is not stored with the data word. It comes from a flag in the control register. That flag is read at the moment the word moves into the shifter, and it clears itself at that same moment. Software therefore waits for the transmitter to drain, sets the flag, and then writes the data.

On the receive side, the input is synchronised and a start bit is qualified at the middle of the bit. Each later bit is sampled at its middle point. A finished word is placed in a receive data register and raises a ready flag.

Top module: `uart9_port`

Register map (`addr`):
- 0: control
  - bit0 transmit enable
  - bit1 receive enable
  - bit2 parity enable
  - bit3 even parity
  - bits6:4 mode
  - bit7 ninth transmit bit
  - bit8 transmit-ready interrupt enable
  - bit9 receive-ready interrupt enable
  - bit10 flow enable (stored only)
- 1: status
  - bit0 receive ready
  - bit1 holding empty
  - bit2 transmitter empty
  - bit3 parity error
- 2: transmit data. Writes only; bits 7:0 are used.
- 3: receive data. Bits 8:0 hold the word.

## Requirements
- R1: After reset, control reads 0, status reads 0x0006, `txd` is 1 and `irq` is 0.
- R2: In mode 1 a word goes out as one frame, least significant bit first. The frame is: a start bit of 0, 8 data bits, a parity bit when parity is enabled, and a stop bit of 1. Each bit holds for 16*DIV clocks.
- R3: In modes 2 and 3 the frame carries a ninth data bit after data bit 7. Its value is control bit7 as it stands when the word enters the shifter. The receiver returns that bit in receive data bit8.
- R4: Control bit7 clears itself in the cycle its word is moved into the shifter.
- R5: With parity enabled, the parity bit follows the last data bit. With control bit3 = 1, the count of ones in the data bits plus parity is even; with bit3 = 0 it is odd. Control bit3 has no effect when parity is disabled.
- R6: Status bit1 is 1 while the holding register is empty. Status bit2 goes to 1 only after the stop bit of the last word has finished and the holding register is empty.
- R7: In three cases a transmit data write is ignored and `txd` stays high: transmit is disabled, or the mode is 0, or the mode is 4 to 7.
- R8: Each received word is sampled at mid-bit and placed in receive data. The word sets status bit0. Reading address 3 clears status bit0.
- R9: A low pulse on `rxd` that is no longer low at the middle of the start bit does not start a word.
- R10: A received parity mismatch sets status bit3. That bit stays set until a status write with bit3 = 1.
- R11: `irq` is high whenever one of these holds: control bit8 and status bit1 are both 1, or control bit9 and status bit0 are both 1. It stays high as long as that holds.
- R12: With receive disabled, traffic on `rxd` does not set status bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears receive ready at address 3) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the control register is not rewritten while a frame is being shifted or received. They also assume that `rxd` frames arrive at the same nominal bit rate. The stimulus keeps to both of these. Every control write happens while both serial directions are idle. Every frame, whether looped back from `txd` or driven by the bench, uses exactly `16*DIV` clocks per bit.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned WORD_W  = DATA_W + 1;
  localparam int unsigned FRAME_W = WORD_W + 3;
  localparam int unsigned OVS     = 16;
  localparam int unsigned SUB_W   = $clog2(OVS);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  typedef struct packed {
    logic       flow_en;
    logic       rx_ie;
    logic       tx_ie;
    logic       tx_bit9;
    logic [2:0] mode;
    logic       par_even;
    logic       par_en;
    logic       rx_en;
    logic       tx_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic mode_ok(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3);
  endfunction

  function automatic logic mode_nine(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx import uart9_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              nine,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              bit9,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              load
);
  logic                hold_full_q, hold_full_d;
  logic [DATA_W-1:0]   hold_q, hold_d;
  logic                busy_q, busy_d;
  logic [FRAME_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0]    left_q, left_d;
  logic [SUB_W-1:0]    sub_q, sub_d;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    nbits;
  logic [WORD_W-1:0]   word;
  logic                par;

  // Frame image built from the holding register and the live ninth-bit flag
  always_comb begin
    word  = {bit9 & nine, hold_q};
    par   = par_even ? ^word : ~(^word);
    frame = '1;
    frame[0] = 1'b0;
    frame[DATA_W:1] = hold_q;
    if (nine) frame[WORD_W] = bit9;
    if (par_en) begin
      if (nine) frame[WORD_W+1] = par;
      else      frame[WORD_W]   = par;
    end
    nbits = CNT_W'(DATA_W + 2) + CNT_W'(nine) + CNT_W'(par_en);
  end

  assign load = enable && hold_full_q && !busy_q;

  always_comb begin
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    busy_d      = busy_q;
    sh_d        = sh_q;
    left_d      = left_q;
    sub_d       = sub_q;
    if (load) begin
      hold_full_d = 1'b0;
      busy_d      = 1'b1;
      sh_d        = frame;
      left_d      = nbits;
      sub_d       = '0;
    end else if (busy_q && tick) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == SUB_W'(OVS - 1)) begin
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        left_d = left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_d = 1'b0;
      end
    end
    if (wr && enable && !hold_full_q) begin
      hold_d      = wdata;
      hold_full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      sh_q        <= '1;
      left_q      <= '0;
      sub_q       <= '0;
    end else begin
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      busy_q      <= busy_d;
      sh_q        <= sh_d;
      left_q      <= left_d;
      sub_q       <= sub_d;
    end
  end

  assign txd         = busy_q ? sh_q[0] : 1'b1;
  assign hold_empty  = !hold_full_q;
  assign shift_empty = !busy_q && !hold_full_q;

  // R2: every frame begins with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (txd == 1'b0));
  // R6: the holding register is free once its word is in the shifter
  a_r6_hold_freed: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold_empty);
  // R6: an empty transmitter leaves the line idle
  a_r6_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx import uart9_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              nine,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              rxd,
  output logic              done,
  output logic              bad_par,
  output logic [WORD_W-1:0] word
);
  logic                s1_q, s2_q;
  logic                active_q, active_d;
  logic [SUB_W-1:0]    sub_q, sub_d;
  logic [CNT_W-1:0]    bitn_q, bitn_d;
  logic [WORD_W-1:0]   buf_q, buf_d;
  logic                parb_q, parb_d;
  logic [CNT_W-1:0]    nd, stop_idx;
  logic                exp_par, mid;

  always_comb begin
    nd       = CNT_W'(DATA_W) + CNT_W'(nine);
    stop_idx = nd + CNT_W'(par_en) + 1'b1;
    exp_par  = par_even ? ^buf_q : ~(^buf_q);
    mid      = active_q && tick && (sub_q == SUB_W'(OVS/2 - 1));
    active_d = active_q;
    sub_d    = sub_q;
    bitn_d   = bitn_q;
    buf_d    = buf_q;
    parb_d   = parb_q;
    done     = 1'b0;
    bad_par  = 1'b0;
    if (!enable) begin
      active_d = 1'b0;
    end else if (!active_q) begin
      if (!s2_q) begin
        active_d = 1'b1;
        sub_d    = '0;
        bitn_d   = '0;
        buf_d    = '0;
        parb_d   = 1'b0;
      end
    end else if (tick) begin
      sub_d = sub_q + 1'b1;
      if (mid) begin
        if (bitn_q == '0 && s2_q) begin
          active_d = 1'b0;
        end else if (bitn_q == stop_idx) begin
          active_d = 1'b0;
          done     = 1'b1;
          bad_par  = par_en && (parb_q != exp_par);
        end else begin
          for (int i = 0; i < WORD_W; i++)
            if (bitn_q == CNT_W'(i + 1) && CNT_W'(i) < nd) buf_d[i] = s2_q;
          if (par_en && bitn_q == nd + 1'b1) parb_d = s2_q;
          bitn_d = bitn_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b1;
      s2_q     <= 1'b1;
      active_q <= 1'b0;
      sub_q    <= '0;
      bitn_q   <= '0;
      buf_q    <= '0;
      parb_q   <= 1'b0;
    end else begin
      s1_q     <= rxd;
      s2_q     <= s1_q;
      active_q <= active_d;
      sub_q    <= sub_d;
      bitn_q   <= bitn_d;
      buf_q    <= buf_d;
      parb_q   <= parb_d;
    end
  end

  assign word = buf_q;

  // R9: a start bit found high at its middle abandons the word
  a_r9_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mid && bitn_q == '0 && s2_q) |=> !active_q);
endmodule

// File: rtl/uart9_port.sv
module uart9_port import uart9_pkg::*; #(
  parameter int unsigned DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             txd,
  input  logic             rxd,
  output logic             irq
);
  logic              r1_q, srst_n;
  logic              tick;
  ctrl_t             ctrl_q, ctrl_d;
  logic              rx_ready_q, rx_ready_d;
  logic              perr_q, perr_d;
  logic [WORD_W-1:0] rx_word_q, rx_word_d;
  logic              hold_empty, shift_empty, tx_load;
  logic              rx_done, rx_bad;
  logic [WORD_W-1:0] rx_word_in;
  logic              rx_read;
  logic              unused_bits;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q   <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      r1_q   <= 1'b1;
      srst_n <= r1_q;
    end
  end

  uart9_baud #(.DIV(DIV)) u_baud (.clk(clk), .rst_n(srst_n), .tick(tick));

  uart9_tx u_tx (
    .clk(clk), .rst_n(srst_n), .tick(tick),
    .enable(ctrl_q.tx_en && mode_ok(ctrl_q.mode)),
    .nine(mode_nine(ctrl_q.mode)), .par_en(ctrl_q.par_en),
    .par_even(ctrl_q.par_even), .bit9(ctrl_q.tx_bit9),
    .wr(wr_en && addr == A_TXD), .wdata(wdata[DATA_W-1:0]),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .load(tx_load)
  );

  uart9_rx u_rx (
    .clk(clk), .rst_n(srst_n), .tick(tick),
    .enable(ctrl_q.rx_en && mode_ok(ctrl_q.mode)),
    .nine(mode_nine(ctrl_q.mode)), .par_en(ctrl_q.par_en),
    .par_even(ctrl_q.par_even), .rxd(rxd),
    .done(rx_done), .bad_par(rx_bad), .word(rx_word_in)
  );

  assign rx_read     = rd_en && addr == A_RXD;
  assign unused_bits = ^wdata[BUS_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && addr == A_CTRL) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (tx_load) ctrl_d.tx_bit9 = 1'b0;
    rx_ready_d = rx_ready_q;
    if (rx_read) rx_ready_d = 1'b0;
    if (rx_done) rx_ready_d = 1'b1;
    rx_word_d = rx_done ? rx_word_in : rx_word_q;
    perr_d = perr_q;
    if (wr_en && addr == A_STAT && wdata[3]) perr_d = 1'b0;
    if (rx_done && rx_bad) perr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q     <= '0;
      rx_ready_q <= 1'b0;
      rx_word_q  <= '0;
      perr_q     <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      rx_ready_q <= rx_ready_d;
      rx_word_q  <= rx_word_d;
      perr_q     <= perr_d;
    end
  end

  assign irq = (ctrl_q.tx_ie && hold_empty) || (ctrl_q.rx_ie && rx_ready_q);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:  rdata = {{(BUS_W-4){1'b0}}, perr_q, shift_empty, hold_empty, rx_ready_q};
      A_RXD:   rdata = {{(BUS_W-WORD_W){1'b0}}, rx_word_q};
      default: rdata = '0;
    endcase
  end

  // R4: the ninth-bit flag is gone the cycle after its word was taken
  a_r4_bit9_cleared: assert property (@(posedge clk) disable iff (!srst_n)
    tx_load |=> !ctrl_q.tx_bit9);
  // R8: receive ready holds until the data register is read
  a_r8_ready_held: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_ready_q && !rx_read) |=> rx_ready_q);
endmodule

// File: tb/tb_uart9_port.sv
module tb_uart9_port;
  localparam int unsigned DIV = 2;
  localparam int unsigned BIT = 16 * DIV;
  localparam int NV = 7;
  // {mode[2:0], par_en, par_even, tb8, data[7:0]}
  localparam logic [13:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b0, 1'b0, 8'hA5},
    {3'd1, 1'b1, 1'b1, 1'b0, 8'h3C},
    {3'd1, 1'b1, 1'b0, 1'b0, 8'h3C},
    {3'd2, 1'b0, 1'b0, 1'b1, 8'h81},
    {3'd3, 1'b1, 1'b1, 1'b0, 8'hFF},
    {3'd2, 1'b1, 1'b0, 1'b1, 8'h00},
    {3'd1, 1'b0, 1'b1, 1'b0, 8'h55}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic        txd, irq;
  logic        loop_en = 1'b0, drv_rx = 1'b1;
  logic        rxd;
  int          checks = 0, errors = 0;

  assign rxd = loop_en ? txd : drv_rx;

  always #4 clk = ~clk;

  uart9_port #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic txen, rxen, pe, ev,
                                     input logic [2:0] m, input logic tb8, txie, rxie);
    return {5'b0, 1'b0, rxie, txie, tb8, m, ev, pe, rxen, txen};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    addr = a; #1 v = rdata;
  endtask

  function automatic void build(input logic [2:0] m, input logic pe, ev, tb8,
                                input logic [7:0] d, output logic [11:0] f, output int n);
    logic nine, w9, p;
    int idx;
    nine = (m != 3'd1);
    w9 = nine ? tb8 : 1'b0;
    p = ev ? ^{w9, d} : ~(^{w9, d});
    f = 12'hFFF; f[0] = 1'b0; f[8:1] = d; idx = 9;
    if (nine) begin f[9] = tb8; idx = 10; end
    if (pe) begin f[idx] = p; idx++; end
    f[idx] = 1'b1;
    n = idx + 1;
  endfunction

  task automatic send_rx(input logic [11:0] f, input int n);
    for (int k = 0; k < n; k++) begin
      drv_rx = f[k];
      repeat (BIT) @(negedge clk);
    end
    drv_rx = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [11:0] f, got;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(2'd0, v); check("R1 ctrl", v, 16'h0000);
    peek(2'd1, v); check("R1 status", v, 16'h0006);
    check("R1 txd", txd, 1'b1);
    check("R1 irq", irq, 1'b0);

    // Vector table: loopback transmit/receive
    loop_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] m; logic pe, ev, tb8; logic [7:0] d;
      {m, pe, ev, tb8, d} = VEC[i];
      build(m, pe, ev, tb8, d, f, n);
      wr(2'd0, cw(1'b1, 1'b1, pe, ev, m, tb8, 1'b0, 1'b0));
      wr(2'd2, {8'h00, d});
      for (int t = 0; t < 3000 && txd; t++) @(negedge clk);
      got = 12'hFFF;
      repeat (BIT/2) @(negedge clk);
      got[0] = txd;
      for (int k = 1; k < n; k++) begin
        repeat (BIT) @(negedge clk);
        got[k] = txd;
      end
      // R2 R3 R5: frame shape, ninth bit, parity
      check("R2/R3/R5 frame", got, f);
      peek(2'd1, v); check("R6 busy during stop", v[2], 1'b0);
      repeat (BIT) @(negedge clk);
      peek(2'd1, v); check("R6 R8 R10 status after frame", v, 16'h0007);
      peek(2'd0, v); check("R4 ninth flag cleared", v[7], 1'b0);
      rd(2'd3, v);
      check("R8 R3 rx word", v, {7'b0, (m != 3'd1) ? tb8 : 1'b0, d});
      peek(2'd1, v); check("R8 ready cleared by read", v[0], 1'b0);
    end

    // R7: transmit disabled, then illegal modes
    for (int c = 0; c < 3; c++) begin
      logic ok;
      logic [2:0] mm;
      mm = (c == 0) ? 3'd1 : (c == 1) ? 3'd0 : 3'd5;
      wr(2'd0, cw(c != 0, 1'b0, 1'b0, 1'b0, mm, 1'b0, 1'b0, 1'b0));
      wr(2'd2, 16'h0000);
      ok = 1'b1;
      for (int t = 0; t < 12 * BIT; t++) begin
        @(negedge clk);
        if (!txd) ok = 1'b0;
      end
      check("R7 line idle", ok, 1'b1);
      peek(2'd1, v); check("R7 write ignored", v[2:1], 2'b11);
    end

    // R12: receive disabled
    wr(2'd0, cw(1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0));
    wr(2'd2, 16'h005A);
    repeat (12 * BIT) @(negedge clk);
    peek(2'd1, v); check("R12 no ready when rx off", v[0], 1'b0);

    // R9: false start
    loop_en = 1'b0;
    wr(2'd0, cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0));
    drv_rx = 1'b0;
    repeat (6) @(negedge clk);
    drv_rx = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    peek(2'd1, v); check("R9 glitch rejected", v[0], 1'b0);

    // R10: parity error sticky and cleared by status write
    wr(2'd0, cw(1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0));
    f = 12'hFFF; f[0] = 1'b0; f[8:1] = 8'h01; f[9] = 1'b0; f[10] = 1'b1;
    send_rx(f, 11);
    peek(2'd1, v); check("R10 parity error set", v[3], 1'b1);
    check("R8 ready after bad parity", v[0], 1'b1);
    repeat (2 * BIT) @(negedge clk);
    peek(2'd1, v); check("R10 parity error sticky", v[3], 1'b1);
    wr(2'd1, 16'h0008);
    peek(2'd1, v); check("R10 parity error cleared", v[3], 1'b0);
    rd(2'd3, v); check("R8 word with bad parity", v, 16'h0001);

    // R11: level interrupt
    wr(2'd0, cw(1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0));
    @(negedge clk); check("R11 tx irq with empty holding", irq, 1'b1);
    repeat (20) @(negedge clk); check("R11 tx irq stays", irq, 1'b1);
    wr(2'd0, cw(1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1));
    @(negedge clk); check("R11 rx irq idle", irq, 1'b0);
    f = 12'hFFF; f[0] = 1'b0; f[8:1] = 8'h3C;
    send_rx(f, 10);
    check("R11 rx irq raised", irq, 1'b1);
    repeat (BIT) @(negedge clk); check("R11 rx irq held", irq, 1'b1);
    rd(2'd3, v); check("R8 rx word direct", v, 16'h003C);
    check("R11 rx irq dropped on read", irq, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule